// File: doc/BRIEF.md
# ADC conversion trigger arbiter

This block sits in front of a single analog-to-digital converter back end and decides which input channel is converted next. Every channel carries its own 5-bit trigger-source code that ties it to a software trigger (one-shot or level), to the shared scan group, or to one of several hardware trigger pulses. A scan group with its own source code and a per-channel membership mask lets one event queue a whole set of channels. Two bypass paths, a direct software request and a request from an external module, name one channel each and are served ahead of everything queued.

Triggered channels are remembered in one pending bit per channel and served lowest index first. For each issued channel the block holds its sample-hold output for a programmed number of converter clocks, or for as long as a manual sampling override stays set. It then pulses a start strobe for one cycle and waits for the converter's done handshake before issuing the next channel.

Top module: `trg_arbiter`

## Requirements
- R1: After synchronous reset, sh_o and cnv_start_o are low, cnv_ch_o is 0 and nothing is pending, so no conversion starts until some trigger arrives.
- R2: Channel source codes: 0 never requests the channel; 1 follows the one-shot software trigger; 2 follows the level software trigger; 3 makes the channel a scan member; 4+n follows hardware trigger input n (n < NUM_HW); any other code never fires.
- R3: Each write pulse on sw_shot_i becomes an internal trigger that lasts exactly one cycle and then clears itself, so every channel on code 1 is converted exactly once per write.
- R4: While sw_level_i stays high, every channel on code 2 is requested again each time it is served, giving back-to-back conversions for as long as the level is held.
- R5: Channels pending together from the queue are issued in ascending channel index.
- R6: The scan group fires when the event chosen by scan_src_i (same code meanings as R2, code 3 and code 0 never fire) occurs; it then requests every channel whose scan_mask_i bit is set or whose own code is 3.
- R7: A trigger for a channel that is already pending is merged into that request and yields one conversion only.
- R8: A pulse on dir_req_i requests channel dir_ch_i and is served before the external and queued requests; an index of NUM_CH or more is ignored and causes no conversion.
- R9: A pulse on ext_req_i requests channel ext_ch_i; it is served after a direct request and before the queue; an index of NUM_CH or more is ignored.
- R10: With man_samp_i low, sh_o stays high for max(samp_time_i,1) cycles with cnv_ch_o steady, cnv_start_o then pulses for exactly one cycle, and sh_o stays low until cnv_done_i has been seen; the next sampling begins no earlier than the second cycle after done.
- R11: While man_samp_i is high, a channel in its sampling phase stays in it regardless of samp_time_i; once the bit drops the conversion starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_src_i | input | NUM_CH*5 | Per-channel trigger-source codes, channel n in bits 5n+4..5n |
| scan_src_i | input | 5 | Scan group trigger-source code |
| scan_mask_i | input | NUM_CH | Scan group membership, one bit per channel |
| hw_trig_i | input | NUM_HW | Hardware trigger pulses |
| sw_shot_i | input | 1 | Software write of the one-shot trigger |
| sw_level_i | input | 1 | Level software trigger |
| dir_ch_i | input | IDX_W | Channel for the direct request |
| dir_req_i | input | 1 | Direct request pulse |
| man_samp_i | input | 1 | Manual sampling override |
| samp_time_i | input | SAMP_W | Sample time in converter clocks |
| ext_ch_i | input | IDX_W | Channel named by the external module |
| ext_req_i | input | 1 | External module request pulse |
| cnv_done_i | input | 1 | Conversion finished handshake |
| cnv_ch_o | output | IDX_W | Channel being sampled or converted |
| cnv_start_o | output | 1 | One-cycle start-conversion strobe |
| sh_o | output | 1 | Sample-hold control, high while sampling |

## Verification
The bench builds the block with eight channels, a 6-bit channel index and two hardware trigger inputs. The wide index against only eight channels makes out-of-range direct and external requests reachable, and two hardware inputs cover both hardware codes together with the orderings between hardware-triggered channels. The 10-bit sample time lets the bench use a zero count, a short count, and a long 20-cycle window that keeps the converter busy while merged, direct, external and queued requests pile up behind it.

// File: rtl/trg_pkg.sv
package trg_pkg;
  localparam int SRC_W = 5;

  localparam logic [SRC_W-1:0] CODE_ONESHOT = 5'd1;
  localparam logic [SRC_W-1:0] CODE_LEVEL   = 5'd2;
  localparam logic [SRC_W-1:0] CODE_SCAN    = 5'd3;
  localparam int               CODE_HW0     = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAMP,
    ST_CONV,
    ST_WAIT
  } seq_st_e;
endpackage

// File: rtl/trg_src_decode.sv
module trg_src_decode
  import trg_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int NUM_HW = 4
) (
  input  logic [NUM_CH*SRC_W-1:0] ch_src_i,
  input  logic [SRC_W-1:0]        scan_src_i,
  input  logic [NUM_CH-1:0]       scan_mask_i,
  input  logic                    shot_i,
  input  logic                    level_i,
  input  logic [NUM_HW-1:0]       hw_i,
  output logic [NUM_CH-1:0]       hit_o
);
  // Event selected by a source code; code 0, code 3 and unmapped codes never fire.
  function automatic logic event_of(input logic [SRC_W-1:0] code,
                                    input logic shot, input logic lvl,
                                    input logic [NUM_HW-1:0] hw);
    logic ev;
    ev = 1'b0;
    if (code == CODE_ONESHOT) ev = shot;
    else if (code == CODE_LEVEL) ev = lvl;
    else begin
      for (int k = 0; k < NUM_HW; k++) begin
        if (code == SRC_W'(CODE_HW0 + k)) ev = hw[k];
      end
    end
    return ev;
  endfunction

  logic scan_ev;
  assign scan_ev = event_of(scan_src_i, shot_i, level_i, hw_i);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [SRC_W-1:0] code;
    logic             member;
    assign code     = ch_src_i[g*SRC_W +: SRC_W];
    assign member   = scan_mask_i[g] | (code == CODE_SCAN);
    assign hit_o[g] = event_of(code, shot_i, level_i, hw_i) | (scan_ev & member);
  end
endmodule

// File: rtl/trg_prio_pick.sv
module trg_prio_pick #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic [N-1:0] req_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = W'(i);
    end
  end
endmodule

// File: rtl/trg_seq.sv
module trg_seq
  import trg_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int SAMP_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [IDX_W-1:0]  ch_i,
  input  logic [SAMP_W-1:0] samp_time_i,
  input  logic              man_i,
  input  logic              done_i,
  output logic              take_o,
  output logic [IDX_W-1:0]  ch_o,
  output logic              sh_o,
  output logic              start_o
);
  seq_st_e           st_q;
  logic [SAMP_W-1:0] cnt_q;
  logic [IDX_W-1:0]  ch_q;
  logic              sh_q;
  logic              start_q;
  logic              samp_end;

  assign take_o   = (st_q == ST_IDLE) && req_i;
  assign samp_end = (cnt_q >= samp_time_i) && !man_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      ch_q    <= '0;
      sh_q    <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (req_i) begin
            st_q  <= ST_SAMP;
            cnt_q <= SAMP_W'(1);
            ch_q  <= ch_i;
            sh_q  <= 1'b1;
          end
        end
        ST_SAMP: begin
          if (samp_end) begin
            st_q    <= ST_CONV;
            sh_q    <= 1'b0;
            start_q <= 1'b1;
          end else if (cnt_q != '1) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_CONV: st_q <= ST_WAIT;
        default: begin
          if (done_i) st_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign ch_o    = ch_q;
  assign sh_o    = sh_q;
  assign start_o = start_q;
endmodule

// File: rtl/trg_arbiter.sv
module trg_arbiter
  import trg_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int NUM_HW = 4,
  parameter int IDX_W  = 6,
  parameter int SAMP_W = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_CH*SRC_W-1:0] ch_src_i,
  input  logic [SRC_W-1:0]        scan_src_i,
  input  logic [NUM_CH-1:0]       scan_mask_i,
  input  logic [NUM_HW-1:0]       hw_trig_i,
  input  logic                    sw_shot_i,
  input  logic                    sw_level_i,
  input  logic [IDX_W-1:0]        dir_ch_i,
  input  logic                    dir_req_i,
  input  logic                    man_samp_i,
  input  logic [SAMP_W-1:0]       samp_time_i,
  input  logic [IDX_W-1:0]        ext_ch_i,
  input  logic                    ext_req_i,
  input  logic                    cnv_done_i,
  output logic [IDX_W-1:0]        cnv_ch_o,
  output logic                    cnv_start_o,
  output logic                    sh_o
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [IDX_W:0] CH_LIMIT = (IDX_W + 1)'(NUM_CH);

  logic              shot_q;
  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] pend_q;
  logic [NUM_CH-1:0] clr;
  logic              q_any;
  logic [CH_W-1:0]   q_idx;
  logic              dir_pend_q, ext_pend_q;
  logic [IDX_W-1:0]  dir_idx_q, ext_idx_q;
  logic              dir_ok, ext_ok;
  logic              req_any, take;
  logic              take_dir, take_ext, take_q;
  logic [IDX_W-1:0]  sel_ch;

  // One-shot trigger: set by a write, gone on the following cycle.
  always_ff @(posedge clk) begin
    if (rst) shot_q <= 1'b0;
    else     shot_q <= sw_shot_i & ~shot_q;
  end

  trg_src_decode #(.NUM_CH(NUM_CH), .NUM_HW(NUM_HW)) u_dec (
    .ch_src_i    (ch_src_i),
    .scan_src_i  (scan_src_i),
    .scan_mask_i (scan_mask_i),
    .shot_i      (shot_q),
    .level_i     (sw_level_i),
    .hw_i        (hw_trig_i),
    .hit_o       (hit)
  );

  trg_prio_pick #(.N(NUM_CH), .W(CH_W)) u_pick (
    .req_i (pend_q),
    .any_o (q_any),
    .idx_o (q_idx)
  );

  assign dir_ok   = {1'b0, dir_ch_i} < CH_LIMIT;
  assign ext_ok   = {1'b0, ext_ch_i} < CH_LIMIT;
  assign req_any  = dir_pend_q | ext_pend_q | q_any;
  assign take_dir = take & dir_pend_q;
  assign take_ext = take & ~dir_pend_q & ext_pend_q;
  assign take_q   = take & ~dir_pend_q & ~ext_pend_q;
  assign clr      = take_q ? ({{(NUM_CH-1){1'b0}}, 1'b1} << q_idx) : '0;

  always_comb begin
    if (dir_pend_q)      sel_ch = dir_idx_q;
    else if (ext_pend_q) sel_ch = ext_idx_q;
    else                 sel_ch = IDX_W'(q_idx);
  end

  // Pending queue: a new trigger wins over the clear of the grant cycle.
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr) | hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_pend_q <= 1'b0;
      dir_idx_q  <= '0;
      ext_pend_q <= 1'b0;
      ext_idx_q  <= '0;
    end else begin
      if (take_dir) dir_pend_q <= 1'b0;
      if (dir_req_i && dir_ok && (!dir_pend_q || take_dir)) begin
        dir_pend_q <= 1'b1;
        dir_idx_q  <= dir_ch_i;
      end
      if (take_ext) ext_pend_q <= 1'b0;
      if (ext_req_i && ext_ok && (!ext_pend_q || take_ext)) begin
        ext_pend_q <= 1'b1;
        ext_idx_q  <= ext_ch_i;
      end
    end
  end

  trg_seq #(.IDX_W(IDX_W), .SAMP_W(SAMP_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req_any),
    .ch_i        (sel_ch),
    .samp_time_i (samp_time_i),
    .man_i       (man_samp_i),
    .done_i      (cnv_done_i),
    .take_o      (take),
    .ch_o        (cnv_ch_o),
    .sh_o        (sh_o),
    .start_o     (cnv_start_o)
  );
endmodule

// File: rtl/trg_arbiter_chk.sv
module trg_arbiter_chk #(
  parameter int NUM_CH = 8,
  parameter int IDX_W  = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             man_samp_i,
  input logic             sh_o,
  input logic             cnv_start_o,
  input logic [IDX_W-1:0] cnv_ch_o
);
  a_r10_start_single: assert property (@(posedge clk) disable iff (rst)
    cnv_start_o |=> !cnv_start_o);

  a_r10_start_after_sample: assert property (@(posedge clk) disable iff (rst)
    cnv_start_o |-> $past(sh_o));

  a_r10_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(sh_o && cnv_start_o));

  a_r10_ch_steady: assert property (@(posedge clk) disable iff (rst)
    cnv_start_o |-> $stable(cnv_ch_o));

  a_r10_wait_after_start: assert property (@(posedge clk) disable iff (rst)
    cnv_start_o |=> !sh_o);

  a_r11_manual_hold: assert property (@(posedge clk) disable iff (rst)
    (sh_o && man_samp_i) |=> sh_o);

  a_r8_ch_range: assert property (@(posedge clk) disable iff (rst)
    (sh_o || cnv_start_o) |-> ({1'b0, cnv_ch_o} < (IDX_W + 1)'(NUM_CH)));
endmodule

bind trg_arbiter trg_arbiter_chk #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/tb_trg_arbiter.sv
module tb_trg_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 8;
  localparam int NUM_HW     = 2;
  localparam int IDX_W      = 6;
  localparam int SAMP_W     = 10;
  localparam int SRC_W      = 5;
  localparam int DONE_LAT   = 3;

  logic                    clk, rst;
  logic [NUM_CH*SRC_W-1:0] ch_src;
  logic [SRC_W-1:0]        scan_src;
  logic [NUM_CH-1:0]       scan_mask;
  logic [NUM_HW-1:0]       hw_trig;
  logic                    sw_shot, sw_level, dir_req, ext_req, man_samp, cnv_done;
  logic [IDX_W-1:0]        dir_ch, ext_ch, cnv_ch;
  logic [SAMP_W-1:0]       samp_time;
  logic                    cnv_start, sh;

  trg_arbiter #(.NUM_CH(NUM_CH), .NUM_HW(NUM_HW), .IDX_W(IDX_W), .SAMP_W(SAMP_W)) dut (
    .clk(clk), .rst(rst), .ch_src_i(ch_src), .scan_src_i(scan_src),
    .scan_mask_i(scan_mask), .hw_trig_i(hw_trig), .sw_shot_i(sw_shot),
    .sw_level_i(sw_level), .dir_ch_i(dir_ch), .dir_req_i(dir_req),
    .man_samp_i(man_samp), .samp_time_i(samp_time), .ext_ch_i(ext_ch),
    .ext_req_i(ext_req), .cnv_done_i(cnv_done), .cnv_ch_o(cnv_ch),
    .cnv_start_o(cnv_start), .sh_o(sh)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int    checks, fails;
  int    exp_ch[$];
  string exp_tag[$];
  int    exp_samp, extra_ch, extra_cnt, start_cnt, slen, base, e;
  bit    chk_len, allow_extra, waiting, done_flag;
  string t;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input int ch, input string tag);
    exp_ch.push_back(ch);
    exp_tag.push_back(tag);
  endtask

  task automatic set_src(input int ch, input int code);
    ch_src[ch*SRC_W +: SRC_W] = SRC_W'(code);
  endtask

  task automatic set_samp(input int n);
    samp_time = SAMP_W'(n);
    exp_samp  = (n > 0) ? n : 1;
  endtask

  task automatic drain();
    while (exp_ch.size() != 0) @(negedge clk);
    cyc(30);
  endtask

  // Converter model: done pulse DONE_LAT cycles after each start strobe.
  initial begin
    cnv_done = 1'b0;
    forever begin
      @(negedge clk);
      if (cnv_start) begin
        cyc(DONE_LAT);
        cnv_done <= 1'b1;
        @(negedge clk);
        cnv_done <= 1'b0;
      end
    end
  end

  // Monitor: pops expected channels as start strobes appear.
  always @(negedge clk) begin
    if (!rst) begin
      if (waiting && cnv_done) waiting = 1'b0;
      if (waiting && sh) check(1'b0, "R10 sampling before done", 1, 0);
      if (sh) slen++;
      if (cnv_start) begin
        start_cnt++;
        waiting = 1'b1;
        if (chk_len) check(slen == exp_samp, "R10 sample length", slen, exp_samp);
        slen = 0;
        if (exp_ch.size() > 0) begin
          e = exp_ch.pop_front();
          t = exp_tag.pop_front();
          check(int'(cnv_ch) == e, t, int'(cnv_ch), e);
        end else if (allow_extra) begin
          extra_cnt++;
          check(int'(cnv_ch) == extra_ch, "R4 burst channel", int'(cnv_ch), extra_ch);
        end else begin
          check(1'b0, "R2/R7/R8 unexpected conversion", int'(cnv_ch), -1);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; ch_src = '0; scan_src = '0; scan_mask = '0; hw_trig = '0;
    sw_shot = 0; sw_level = 0; dir_req = 0; ext_req = 0; man_samp = 0;
    dir_ch = '0; ext_ch = '0; set_samp(3);
    chk_len = 1; allow_extra = 0; waiting = 0; done_flag = 0;
    cyc(4);
    rst = 1'b0;
    // R1: reset state
    check(sh == 1'b0, "R1 sh after reset", sh, 0);
    check(cnv_start == 1'b0, "R1 start after reset", cnv_start, 0);
    check(cnv_ch == '0, "R1 channel after reset", int'(cnv_ch), 0);
    cyc(10);
    check(start_cnt == 0, "R1 nothing pending", start_cnt, 0);

    // R3/R5/R2: one-shot on ch1 and ch3, ch5 on code 0
    set_src(1, 1); set_src(3, 1); set_src(5, 0);
    push(1, "R5 one-shot first ch1");
    push(3, "R5 one-shot second ch3");
    base = start_cnt;
    sw_shot = 1; cyc(1); sw_shot = 0;
    drain();
    check(start_cnt - base == 2, "R3 one conversion per channel", start_cnt - base, 2);
    set_src(1, 0); set_src(3, 0);

    // R4: level trigger burst on ch2
    set_src(2, 2);
    allow_extra = 1; extra_ch = 2; extra_cnt = 0;
    sw_level = 1; cyc(60); sw_level = 0; cyc(40);
    allow_extra = 0;
    check(extra_cnt >= 3, "R4 repeated conversions while held", extra_cnt, 3);
    set_src(2, 0);

    // R6: scan on one-shot, mask ch0/ch6, ch4 member by code 3
    scan_src = 5'd1; scan_mask = 8'b0100_0001; set_src(4, 3);
    push(0, "R6 scan ch0"); push(4, "R6 scan ch4"); push(6, "R6 scan ch6");
    sw_shot = 1; cyc(1); sw_shot = 0;
    drain();
    scan_src = '0; scan_mask = '0; set_src(4, 0);

    // R2: hardware codes 4 (hw0) and 5 (hw1)
    set_src(7, 4); set_src(3, 5);
    push(3, "R2 hw1 selects ch3");
    hw_trig = 2'b10; cyc(1); hw_trig = '0;
    drain();
    push(7, "R2 hw0 selects ch7");
    hw_trig = 2'b01; cyc(1); hw_trig = '0;
    drain();
    set_src(7, 0);

    // R7: double trigger on pending ch3 merges
    set_samp(20);
    set_src(0, 4);
    push(0, "R7 busy ch0"); push(3, "R7 merged ch3 once");
    hw_trig = 2'b01; cyc(1); hw_trig = '0;
    cyc(3); hw_trig = 2'b10; cyc(1); hw_trig = '0;
    cyc(2); hw_trig = 2'b10; cyc(1); hw_trig = '0;
    drain();

    // R8/R9: direct beats external beats queue
    push(0, "R8 busy ch0"); push(6, "R8 direct first");
    push(5, "R9 external second"); push(3, "R9 queue last");
    hw_trig = 2'b01; cyc(1); hw_trig = '0;
    cyc(3); hw_trig = 2'b10; cyc(1); hw_trig = '0;
    ext_ch = 6'd5; ext_req = 1; cyc(1); ext_req = 0;
    dir_ch = 6'd6; dir_req = 1; cyc(1); dir_req = 0;
    drain();
    set_src(0, 0); set_src(3, 0);

    // R8/R9: out-of-range indices ignored
    set_samp(2);
    base = start_cnt;
    dir_ch = 6'd9; dir_req = 1; cyc(1); dir_req = 0;
    ext_ch = 6'd12; ext_req = 1; cyc(1); ext_req = 0;
    cyc(30);
    check(start_cnt == base, "R8 R9 out-of-range request ignored", start_cnt - base, 0);

    // R10: zero sample time gives one sampling cycle
    set_samp(0);
    push(4, "R10 zero sample time ch4");
    dir_ch = 6'd4; dir_req = 1; cyc(1); dir_req = 0;
    drain();

    // R11: manual sampling override
    set_samp(2);
    chk_len = 0; man_samp = 1;
    base = start_cnt;
    push(2, "R11 manual channel");
    dir_ch = 6'd2; dir_req = 1; cyc(1); dir_req = 0;
    cyc(15);
    check(sh == 1'b1, "R11 still sampling", sh, 1);
    check(start_cnt == base, "R11 no start while held", start_cnt - base, 0);
    man_samp = 0;
    drain();
    chk_len = 1;

    summary();
    $finish;
  end
endmodule